// File: doc/BRIEF.md
# Cascadable Serial Bitstream Reader

This block is the read side of a serial configuration store. It holds a bitstream in an internal bit array and shifts it out one bit per rising edge of a configuration clock that the FPGA being configured supplies. Several of these blocks can be chained. Each one drives its serial output only while its own chip select is low. When its region has been fully read, it pulls its downstream chip select low so that the next block in the chain takes over.

Reading can start at the bottom of the whole array or, when banking is enabled, at one of four equal banks. A 2-bit selector picks the bank. A synchronous active-low clear puts the read position back to the start of the region. After power-up, a timer keeps the block quiet for a set number of clocks and shows this on a status pin. When read mode is off, the block is in programming mode. In that mode the read path is idle and a load port writes the array.

The load port uses a valid/ready handshake. A bit is written on a clock edge where `ld_valid` and `ld_ready` are both high. `ld_ready` is high only in programming mode, so in read mode the block holds off every load attempt. A source must keep `ld_addr` and `ld_bit` stable while it waits for ready. The serial output has no back-pressure because the FPGA owns the clock. The tri-state pin is modelled as a value `sdo` together with an enable `sdo_oe`.

Top module: `scfg_reader`

## Requirements
- R1: After `pwr_rst_n` is released, `rdy_pull_low` stays 1 for exactly POR_CYCLES rising edges and is 0 from then on. While it is 1, `sdo_oe` is 0 and `next_cs_n` is 1.
- R2: With `bank_en`=0, `read_mode`=1, `cs_n`=0 and `ctr_clr_n`=1, the block shows the bit at array address 0 first. Each rising edge then moves the output to the next address, up to address DEPTH-1.
- R3: With `bank_en`=1, reading starts at address `bank_sel`×(DEPTH/4) and covers DEPTH/4 bits.
- R4: On the edge that consumes the last bit of the region, `sdo_oe` goes to 0 and `next_cs_n` goes to 0. Both stay that way, and the read position does not wrap, until `ctr_clr_n` is driven low.
- R5: While `cs_n`=1, `sdo_oe` is 0 and the read position holds. When `cs_n` returns low, reading resumes at the same bit.
- R6: While `ctr_clr_n`=0, `sdo_oe` is 0. Each edge seen with it low returns the read position to the start of the region and sets `next_cs_n` to 1.
- R7: While `read_mode`=0, `sdo_oe` is 0 and `ld_ready` is 1, and loads are written. While `read_mode`=1, `ld_ready` is 0 and a load attempt leaves the array unchanged.
- R8: Whenever `sdo_oe` is 0, `sdo` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock supplied by the FPGA |
| pwr_rst_n | input | 1 | Asynchronous power-up reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ctr_clr_n | input | 1 | Synchronous read-position clear and output enable, active low |
| read_mode | input | 1 | 1 selects read mode, 0 selects programming mode |
| bank_en | input | 1 | 1 restricts reading to one bank |
| bank_sel | input | 2 | Bank number used when banking is enabled |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | Load accepted (high in programming mode) |
| ld_addr | input | $clog2(DEPTH) | Array address to write |
| ld_bit | input | 1 | Bit value to write |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Serial data driver enable |
| next_cs_n | output | 1 | Chip select for the next block in the chain, active low |
| rdy_pull_low | output | 1 | 1 while the power-up cycle runs (status pin pulled low) |

## Verification
The bench fills the array with a computed pattern. It then sweeps a full unbanked read and a read of each of the four banks, comparing every bit against the pattern at the expected address. A block with a wrong bank base or an off-by-one end would show the wrong bit, or release the output one edge early or late. The bench also checks the power-up window edge by edge, so a timer that is one cycle short or long is caught. It pauses a read with chip select high and then resumes it. If the position moved during the pause, the block would skip bits. After the end of the region it keeps clocking, where a wrapping counter would drive data again. Finally it attempts a load while in read mode and then reads the target address back through a normal read, so a write that leaks through in read mode shows up at the output.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_SEL_W = 2;

  typedef enum logic [2:0] {
    ST_POWERUP,
    ST_PROGRAM,
    ST_STANDBY,
    ST_CLEARING,
    ST_STREAM,
    ST_FINISHED
  } rd_state_e;
endpackage

// File: rtl/scfg_por_timer.sv
module scfg_por_timer #(
  parameter int POR_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic por_done
);
  localparam int CW = $clog2(POR_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      por_done <= 1'b0;
    end else if (!por_done) begin
      if (cnt == CW'(POR_CYCLES - 1)) por_done <= 1'b1;
      else                            cnt      <= cnt + 1'b1;
    end
  end

  // R1: once finished the power-up window never reopens
  a_r1_por_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    por_done |=> por_done);
endmodule

// File: rtl/scfg_bit_store.sv
module scfg_bit_store #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_bit;
  end

  assign rd_bit = mem[rd_addr];
endmodule

// File: rtl/scfg_addr_seq.sv
module scfg_addr_seq
  import scfg_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int BANK_BITS = DEPTH / NUM_BANKS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  adv,
  input  logic                  bank_en,
  input  logic [BANK_SEL_W-1:0] bank_sel,
  output logic [AW-1:0]         rd_addr,
  output logic                  done
);
  logic [AW-1:0] offs;
  logic [AW-1:0] base;
  logic [AW-1:0] last_off;

  always_comb begin
    if (bank_en) begin
      base     = AW'(bank_sel) * AW'(BANK_BITS);
      last_off = AW'(BANK_BITS - 1);
    end else begin
      base     = '0;
      last_off = AW'(DEPTH - 1);
    end
  end

  assign rd_addr = base + offs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offs <= '0;
      done <= 1'b0;
    end else if (clr) begin
      offs <= '0;
      done <= 1'b0;
    end else if (adv) begin
      if (offs == last_off) done <= 1'b1;
      else                  offs <= offs + 1'b1;
    end
  end

  // R6: a clear returns to the start of the region
  a_r6_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rd_addr == base) && !done);
  // R4: the end state persists until a clear
  a_r4_end_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> done);
endmodule

// File: rtl/scfg_reader.sv
module scfg_reader
  import scfg_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int POR_CYCLES = 6,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                  cclk,
  input  logic                  pwr_rst_n,
  input  logic                  cs_n,
  input  logic                  ctr_clr_n,
  input  logic                  read_mode,
  input  logic                  bank_en,
  input  logic [BANK_SEL_W-1:0] bank_sel,
  input  logic                  ld_valid,
  output logic                  ld_ready,
  input  logic [AW-1:0]         ld_addr,
  input  logic                  ld_bit,
  output logic                  sdo,
  output logic                  sdo_oe,
  output logic                  next_cs_n,
  output logic                  rdy_pull_low
);
  logic          por_done;
  logic          done;
  logic          adv;
  logic          cur_bit;
  logic [AW-1:0] rd_addr;
  rd_state_e     st;

  scfg_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(cclk), .rst_n(pwr_rst_n), .por_done(por_done)
  );

  scfg_bit_store #(.DEPTH(DEPTH)) u_store (
    .clk(cclk), .wr_en(ld_valid && ld_ready), .wr_addr(ld_addr),
    .wr_bit(ld_bit), .rd_addr(rd_addr), .rd_bit(cur_bit)
  );

  scfg_addr_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(cclk), .rst_n(pwr_rst_n), .clr(!ctr_clr_n), .adv(adv),
    .bank_en(bank_en), .bank_sel(bank_sel), .rd_addr(rd_addr), .done(done)
  );

  always_comb begin
    if (!por_done)       st = ST_POWERUP;
    else if (!read_mode) st = ST_PROGRAM;
    else if (cs_n)       st = ST_STANDBY;
    else if (!ctr_clr_n) st = ST_CLEARING;
    else if (done)       st = ST_FINISHED;
    else                 st = ST_STREAM;
  end

  assign adv          = (st == ST_STREAM);
  assign sdo_oe       = adv;
  assign sdo          = adv ? cur_bit : 1'b0;
  assign next_cs_n    = !done;
  assign ld_ready     = !read_mode;
  assign rdy_pull_low = !por_done;

  // R1: quiet during the power-up window
  a_r1_quiet_powerup: assert property (@(posedge cclk) disable iff (!pwr_rst_n)
    rdy_pull_low |-> (!sdo_oe && next_cs_n));
  // R5: standby holds the read position
  a_r5_standby_hold: assert property (@(posedge cclk) disable iff (!pwr_rst_n)
    (cs_n && ctr_clr_n && $stable(bank_en) && $stable(bank_sel)) |=> $stable(rd_addr));
  // R7: programming mode never drives the serial line
  a_r7_prog_no_drive: assert property (@(posedge cclk) disable iff (!pwr_rst_n)
    !read_mode |-> !sdo_oe);
  // R8: undriven output reads zero
  a_r8_idle_zero: assert property (@(posedge cclk) disable iff (!pwr_rst_n)
    !sdo_oe |-> !sdo);
  // R4: downstream select only while this block is silent
  a_r4_handoff_silent: assert property (@(posedge cclk) disable iff (!pwr_rst_n)
    !next_cs_n |-> !sdo_oe);
endmodule

// File: tb/scfg_reader_bench.sv
module scfg_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int POR = 6;
  localparam int AW = $clog2(DEPTH);
  localparam int BANK = DEPTH / 4;

  logic cclk = 1'b0;
  logic pwr_rst_n = 1'b0;
  logic cs_n = 1'b1, ctr_clr_n = 1'b1, read_mode = 1'b0, bank_en = 1'b0;
  logic [1:0] bank_sel = 2'd0;
  logic ld_valid = 1'b0, ld_bit = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic ld_ready, sdo, sdo_oe, next_cs_n, rdy_pull_low;

  int n_chk = 0, n_fail = 0;

  scfg_reader #(.DEPTH(DEPTH), .POR_CYCLES(POR)) u_scfg_reader (
    .cclk(cclk), .pwr_rst_n(pwr_rst_n), .cs_n(cs_n), .ctr_clr_n(ctr_clr_n),
    .read_mode(read_mode), .bank_en(bank_en), .bank_sel(bank_sel),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_bit(ld_bit),
    .sdo(sdo), .sdo_oe(sdo_oe), .next_cs_n(next_cs_n), .rdy_pull_low(rdy_pull_low)
  );

  always #(CLK_PERIOD/2) cclk = ~cclk;

  function automatic logic pat(int a);
    return logic'(((a * 37 + 11) % 7) < 3);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge cclk); #2;
  endtask

  task automatic stream(string req, int base, int len);
    for (int i = 0; i < len; i++) begin
      #1;
      chk({req, " oe"}, sdo_oe, 1);
      chk({req, " bit"}, sdo, pat(base + i));
      chk({req, " next_cs_n"}, next_cs_n, 1);
      tick();
    end
    #1;
    chk("R4 oe off at end", sdo_oe, 0);
    chk("R4 next_cs_n low at end", next_cs_n, 0);
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge cclk); wd++; end
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R7: load whole array in programming mode
    #1;
    chk("R7 ld_ready in program mode", ld_ready, 1);
    for (int a = 0; a < DEPTH; a++) begin
      ld_valid = 1'b1; ld_addr = AW'(a); ld_bit = pat(a);
      tick();
    end
    ld_valid = 1'b0;
    read_mode = 1'b1; cs_n = 1'b0;
    #1;
    chk("R1 rdy_pull_low in reset", rdy_pull_low, 1);
    chk("R7 ld_ready low in read mode", ld_ready, 0);
    // R1: power-up window
    pwr_rst_n = 1'b1;
    for (int k = 1; k <= POR; k++) begin
      tick(); #1;
      chk("R1 rdy_pull_low window", rdy_pull_low, (k < POR) ? 1 : 0);
      if (k < POR) begin
        chk("R1 no drive", sdo_oe, 0);
        chk("R1 next_cs_n high", next_cs_n, 1);
      end
    end
    // R2: unbanked with an R5 pause
    for (int i = 0; i < 10; i++) begin
      chk("R2 oe", sdo_oe, 1);
      chk("R2 bit", sdo, pat(i));
      tick(); #1;
    end
    cs_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R5 standby oe", sdo_oe, 0);
      chk("R8 sdo zero in standby", sdo, 0);
      tick();
    end
    cs_n = 1'b0; #1;
    chk("R5 resume same bit", sdo, pat(10));
    tick();
    stream("R2 tail", 11, DEPTH - 11);
    for (int i = 0; i < 4; i++) begin
      tick(); #1;
      chk("R4 no wrap oe", sdo_oe, 0);
      chk("R4 next_cs_n stays low", next_cs_n, 0);
      chk("R8 sdo zero after end", sdo, 0);
    end
    // R6: clear after end
    ctr_clr_n = 1'b0; #1;
    chk("R6 oe off during clear", sdo_oe, 0);
    tick(); #1;
    chk("R6 next_cs_n released", next_cs_n, 1);
    ctr_clr_n = 1'b1; #1;
    chk("R6 restart bit", sdo, pat(0));
    // R3: each bank
    for (int s = 0; s < 4; s++) begin
      ctr_clr_n = 1'b0; bank_en = 1'b1; bank_sel = 2'(s);
      tick();
      ctr_clr_n = 1'b1;
      stream("R3 bank", s * BANK, BANK);
    end
    // R6: mid-stream clear in bank 2
    ctr_clr_n = 1'b0; bank_sel = 2'd2; tick(); ctr_clr_n = 1'b1;
    for (int i = 0; i < 5; i++) tick();
    #1; chk("R3 bank2 mid", sdo, pat(2 * BANK + 5));
    ctr_clr_n = 1'b0; tick(); ctr_clr_n = 1'b1;
    stream("R6 after mid clear", 2 * BANK, BANK);
    // R7: program mode is silent; read-mode load ignored
    read_mode = 1'b0; ctr_clr_n = 1'b0; #1;
    chk("R7 program mode oe", sdo_oe, 0);
    tick();
    read_mode = 1'b1; ctr_clr_n = 1'b1; bank_en = 1'b0;
    ld_valid = 1'b1; ld_addr = '0; ld_bit = ~pat(0);
    #1;
    chk("R7 ld_ready low in read mode", ld_ready, 0);
    chk("R7 array unchanged by refused load", sdo, pat(0));
    tick(); ld_valid = 1'b0;
    ctr_clr_n = 1'b0; tick(); ctr_clr_n = 1'b1; #1;
    chk("R7 address 0 after refused load", sdo, pat(0));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule